// File: doc/BRIEF.md
# Inter-core mailbox bank with bitwise set and clear

The block holds a bank of 32-bit mailboxes that processor cores use to signal one another. Each of the cores owns a small group of mailboxes. Any agent on the register bus may raise bits in any mailbox by writing ones to that mailbox's set address. The owning core removes bits by writing ones to the clear address. Both writes act bitwise: a zero in the written word leaves the matching mailbox bit alone. A mailbox requests attention for as long as at least one of its bits is set, so a core that clears only part of a message keeps its interrupt until the last bit is gone.

Each core has one routing control register. It holds an IRQ enable and an FIQ enable for each of the core's mailboxes. When a mailbox with a pending request has its FIQ enable set, the request drives the core's FIQ line and never its IRQ line. Two read-only status words per core show which mailbox requests are currently routed to IRQ and which to FIQ. The bus is a single-cycle register port: a write takes effect at the clock edge, and read data follows the address combinationally.

Top module: `core_mbox_hub`

## Requirements
- R1: After reset every mailbox reads 0, every routing control register reads 0, and all irq_o and fiq_o bits are low.
- R2: A write to 0x80 + 16*n + 4*m ORs the ones of the written word into mailbox m of core n. Written zeros leave the mailbox bits unchanged.
- R3: A write to 0xC0 + 16*n + 4*m clears, in mailbox m of core n, the bits that are one in the written word. All other bits keep their values.
- R4: A read of a clear address returns the current contents of that mailbox. A read of a set address returns 0.
- R5: A mailbox's request is high exactly while its contents are non-zero. After a partial clear the request stays high, and it drops only after the write that clears the last set bit.
- R6: The routing control register of core n is at 0x50 + 4*n. Bit m is the IRQ enable and bit 4+m is the FIQ enable of mailbox m. A write loads bits [7:0], and a read returns them with bits [31:8] as 0.
- R7: irq_o[n] is high exactly when some mailbox m of core n has a request, its IRQ enable set and its FIQ enable clear.
- R8: fiq_o[n] is high exactly when some mailbox m of core n has a request and its FIQ enable set. The FIQ enable overrides the IRQ enable.
- R9: A read of 0x60 + 4*n returns, in bits [7:4], the mailboxes of core n whose request is routed to IRQ (bit 4+m for mailbox m). A read of 0x70 + 4*n returns the FIQ-routed requests in the same bits. All other bits read 0.
- R10: A write changes only the register it addresses. A write to an unmapped or misaligned address (addr[1:0] not 0) changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 4 | Per-core IRQ line |
| fiq_o | output | 4 | Per-core FIQ line |

## Verification
The bench uses the default parameters: four cores, four mailboxes per core, 32-bit words and an 8-bit address. Because the bank has only sixteen mailboxes, the bench can drive every mailbox from several writers, strip the bits away one at a time, and confirm after each step that the request survives until the final clear. With four mailboxes per core, a core has 16 request patterns and 256 routing words. The bench sweeps all 4096 combinations on every core and compares both the lines and the status words against routing it computes itself.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Register bases; the per-core and per-mailbox strides are part of the map
  localparam int unsigned SET_BASE   = 32'h80;
  localparam int unsigned CLR_BASE   = 32'hC0;
  localparam int unsigned CTL_BASE   = 32'h50;
  localparam int unsigned IRQP_BASE  = 32'h60;
  localparam int unsigned FIQP_BASE  = 32'h70;
  localparam int unsigned CORE_STEP  = 16;
  localparam int unsigned BOX_STEP   = 4;
  localparam int unsigned REG_STEP   = 4;
  localparam int unsigned PEND_LSB   = 4;

  function automatic int unsigned set_addr(int unsigned core, int unsigned box);
    return SET_BASE + CORE_STEP * core + BOX_STEP * box;
  endfunction

  function automatic int unsigned clr_addr(int unsigned core, int unsigned box);
    return CLR_BASE + CORE_STEP * core + BOX_STEP * box;
  endfunction

  function automatic int unsigned ctl_addr(int unsigned core);
    return CTL_BASE + REG_STEP * core;
  endfunction

  function automatic int unsigned irqp_addr(int unsigned core);
    return IRQP_BASE + REG_STEP * core;
  endfunction

  function automatic int unsigned fiqp_addr(int unsigned core);
    return FIQP_BASE + REG_STEP * core;
  endfunction

  // Routing of one request: bit 1 = FIQ, bit 0 = IRQ; FIQ enable overrides
  function automatic logic [1:0] route_one(logic req, logic irq_en, logic fiq_en);
    logic [1:0] r;
    r[1] = req & fiq_en;
    r[0] = req & irq_en & ~fiq_en;
    return r;
  endfunction

endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int N_BOX   = 4,
  parameter int ADDR_W  = 8,
  localparam int N_ALL  = N_CORES * N_BOX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_ALL-1:0]  set_hit_o,
  output logic [N_ALL-1:0]  clr_hit_o,
  output logic [N_CORES-1:0] ctl_hit_o
);

  logic aligned;
  assign aligned = (addr_i[1:0] == 2'b00);

  for (genvar n = 0; n < N_CORES; n++) begin : g_core
    assign ctl_hit_o[n] = we_i && aligned &&
                          (int'(unsigned'(addr_i)) == ctl_addr(n));
    for (genvar m = 0; m < N_BOX; m++) begin : g_box
      assign set_hit_o[n*N_BOX+m] = we_i && aligned &&
                                    (int'(unsigned'(addr_i)) == set_addr(n, m));
      assign clr_hit_o[n*N_BOX+m] = we_i && aligned &&
                                    (int'(unsigned'(addr_i)) == clr_addr(n, m));
    end
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_hit_o, clr_hit_o, ctl_hit_o})); // R10

  AST_QUIET_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |-> (set_hit_o == '0 && clr_hit_o == '0 && ctl_hit_o == '0)); // R10

endmodule

// File: rtl/mbox_cell.sv
module mbox_cell #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] box_o,
  output logic          req_o
);

  logic [DW-1:0] box_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      box_q <= '0;
    end else if (set_i) begin
      box_q <= box_q | data_i;
    end else if (clr_i) begin
      box_q <= box_q & ~data_i;
    end
  end

  assign box_o = box_q;
  assign req_o = |box_q;

  AST_SET_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> ((box_q & $past(data_i)) == $past(data_i)) &&
              ((box_q & ~$past(data_i)) == ($past(box_q) & ~$past(data_i)))); // R2

  AST_CLR_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> (box_q == ($past(box_q) & ~$past(data_i)))); // R3

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(box_q)); // R10

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_o) |-> $past(clr_i)); // R5

endmodule

// File: rtl/mbox_route.sv
module mbox_route
  import mbox_pkg::*;
#(
  parameter int N_BOX = 4,
  parameter int DW    = 32,
  localparam int CW   = 2 * N_BOX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we_i,
  input  logic [DW-1:0]    data_i,
  input  logic [N_BOX-1:0] req_i,
  output logic [CW-1:0]    ctl_o,
  output logic [N_BOX-1:0] irq_vec_o,
  output logic [N_BOX-1:0] fiq_vec_o,
  output logic             irq_o,
  output logic             fiq_o
);

  logic [CW-1:0] ctl_q;
  logic          unused_hi;

  assign unused_hi = ^data_i[DW-1:CW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_we_i) begin
      ctl_q <= data_i[CW-1:0];
    end
  end

  for (genvar m = 0; m < N_BOX; m++) begin : g_box
    logic [1:0] r;
    assign r            = route_one(req_i[m], ctl_q[m], ctl_q[N_BOX+m]);
    assign irq_vec_o[m] = r[0];
    assign fiq_vec_o[m] = r[1];

    AST_FIQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i[m] && ctl_q[N_BOX+m]) |-> (fiq_o && !irq_vec_o[m])); // R8

    AST_IRQ_PATH: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i[m] && ctl_q[m] && !ctl_q[N_BOX+m]) |-> irq_o); // R7
  end

  assign ctl_o = ctl_q;
  assign irq_o = |irq_vec_o;
  assign fiq_o = |fiq_vec_o;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i == '0) |-> (!irq_o && !fiq_o)); // R5

  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we_i |=> (ctl_q == $past(data_i[CW-1:0]))); // R6

endmodule

// File: rtl/core_mbox_hub.sv
module core_mbox_hub
  import mbox_pkg::*;
#(
  parameter int N_CORES = 4,
  parameter int N_BOX   = 4,
  parameter int DW      = 32,
  parameter int ADDR_W  = 8,
  localparam int N_ALL  = N_CORES * N_BOX,
  localparam int CW     = 2 * N_BOX
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic [N_CORES-1:0] irq_o,
  output logic [N_CORES-1:0] fiq_o
);

  logic [N_ALL-1:0]   set_hit;
  logic [N_ALL-1:0]   clr_hit;
  logic [N_CORES-1:0] ctl_hit;
  logic [DW-1:0]      box    [N_ALL];
  logic [N_ALL-1:0]   req;
  logic [CW-1:0]      ctl    [N_CORES];
  logic [N_BOX-1:0]   irq_vec[N_CORES];
  logic [N_BOX-1:0]   fiq_vec[N_CORES];

  mbox_decode #(
    .N_CORES(N_CORES), .N_BOX(N_BOX), .ADDR_W(ADDR_W)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
    .set_hit_o(set_hit), .clr_hit_o(clr_hit), .ctl_hit_o(ctl_hit)
  );

  for (genvar i = 0; i < N_ALL; i++) begin : g_cell
    mbox_cell #(.DW(DW)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .set_i(set_hit[i]), .clr_i(clr_hit[i]), .data_i(bus_wdata),
      .box_o(box[i]), .req_o(req[i])
    );
  end

  for (genvar n = 0; n < N_CORES; n++) begin : g_core
    mbox_route #(.N_BOX(N_BOX), .DW(DW)) u_route (
      .clk(clk), .rst_n(rst_n),
      .ctl_we_i(ctl_hit[n]), .data_i(bus_wdata),
      .req_i(req[n*N_BOX +: N_BOX]),
      .ctl_o(ctl[n]), .irq_vec_o(irq_vec[n]), .fiq_vec_o(fiq_vec[n]),
      .irq_o(irq_o[n]), .fiq_o(fiq_o[n])
    );
  end

  // Read side: clear addresses show contents, set addresses read as zero
  always_comb begin
    bus_rdata = '0;
    for (int n = 0; n < N_CORES; n++) begin
      if (int'(unsigned'(bus_addr)) == ctl_addr(n))
        bus_rdata[CW-1:0] = ctl[n];
      if (int'(unsigned'(bus_addr)) == irqp_addr(n))
        bus_rdata[PEND_LSB +: N_BOX] = irq_vec[n];
      if (int'(unsigned'(bus_addr)) == fiqp_addr(n))
        bus_rdata[PEND_LSB +: N_BOX] = fiq_vec[n];
      for (int m = 0; m < N_BOX; m++) begin
        if (int'(unsigned'(bus_addr)) == clr_addr(n, m))
          bus_rdata = box[n*N_BOX+m];
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_o == '0 && fiq_o == '0)); // R1

  AST_LINES_NEED_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req == '0) |-> (irq_o == '0 && fiq_o == '0)); // R5

endmodule

// File: tb/sim_core_mbox_hub.sv
module sim_core_mbox_hub;
  localparam int CLK_PER = 10;
  localparam int NC = 4;
  localparam int NB = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mb  [16];
  logic [7:0]  ctl [4];

  core_mbox_hub u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
  );

  always #(CLK_PER/2) clk = ~clk;

  function automatic logic [7:0] a_set(int n, int m); return 8'(128 + 16*n + 4*m); endfunction
  function automatic logic [7:0] a_clr(int n, int m); return 8'(192 + 16*n + 4*m); endfunction

  // Per-core expected routing: [3:0] IRQ-routed, [7:4] FIQ-routed
  function automatic logic [7:0] exp_route(int n);
    logic [7:0] r = '0;
    for (int m = 0; m < NB; m++) begin
      if (mb[n*NB+m] != 0) begin
        if (ctl[n][4+m]) r[4+m] = 1'b1;
        else if (ctl[n][m]) r[m] = 1'b1;
      end
    end
    return r;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic chk_lines(string req);
    logic [3:0] ei, ef;
    for (int n = 0; n < NC; n++) begin
      logic [7:0] r = exp_route(n);
      ei[n] = |r[3:0];
      ef[n] = |r[7:4];
    end
    chk(req, "irq_o", {28'h0, irq_o}, {28'h0, ei});
    chk(req, "fiq_o", {28'h0, fiq_o}, {28'h0, ef});
  endtask

  task automatic chk_boxes(string req);
    logic [31:0] d;
    for (int i = 0; i < 16; i++) begin
      rd(a_clr(i/NB, i%NB), d);
      chk(req, "box contents", d, mb[i]);
    end
  endtask

  task automatic chk_pend(int n, string req);
    logic [31:0] d;
    logic [7:0] r = exp_route(n);
    rd(8'(8'h60 + 4*n), d);
    chk(req, "irq pending", d, {24'h0, r[3:0], 4'h0});
    rd(8'(8'h70 + 4*n), d);
    chk(req, "fiq pending", d, {24'h0, r[7:4], 4'h0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 16; i++) mb[i] = '0;
    for (int n = 0; n < NC; n++) ctl[n] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk_boxes("R1");
    for (int n = 0; n < NC; n++) begin
      rd(8'(8'h50 + 4*n), d);
      chk("R1", "ctl reset", d, 32'h0);
    end
    chk_lines("R1");

    // R6: control readback, upper bits dropped
    wr(8'h54, 32'hFFFF_FFFF);
    rd(8'h54, d);
    chk("R6", "ctl readback", d, 32'h0000_00FF);
    for (int n = 0; n < NC; n++) begin
      wr(8'(8'h50 + 4*n), 32'h0000_000F);
      ctl[n] = 8'h0F;
    end

    // R2, R4, R5, R7: four writers OR bits into every mailbox
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 4; k++) begin
        logic [31:0] bits = 32'h1 << (k*8 + (i % 8));
        wr(a_set(i/NB, i%NB), bits);
        mb[i] = mb[i] | bits;
        rd(a_clr(i/NB, i%NB), d);
        chk("R2", "set accumulate", d, mb[i]);
        chk_lines("R7");
      end
      rd(a_set(i/NB, i%NB), d);
      chk("R4", "set addr reads zero", d, 32'h0);
    end
    wr(a_set(1, 2), 32'h0);
    chk_boxes("R2");

    // R3, R5: strip bits one at a time; request holds until the last
    for (int i = 0; i < 16; i++) begin
      for (int k = 0; k < 4; k++) begin
        logic [31:0] bits = 32'h1 << (k*8 + (i % 8));
        wr(a_clr(i/NB, i%NB), bits | 32'h8000_0000 & ~mb[i]);
        mb[i] = mb[i] & ~(bits | (32'h8000_0000 & ~mb[i]));
        rd(a_clr(i/NB, i%NB), d);
        chk("R3", "partial clear", d, mb[i]);
        chk_lines("R5");
      end
    end
    chk_boxes("R3");

    // R10: misaligned and unmapped writes change nothing
    wr(a_set(0, 0), 32'h0000_00A5);
    mb[0] = 32'h0000_00A5;
    wr(8'h81, 32'hFFFF_FFFF);
    wr(8'hC1, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    wr(8'h60, 32'hFFFF_FFFF);
    chk_boxes("R10");
    for (int n = 0; n < NC; n++) begin
      rd(8'(8'h50 + 4*n), d);
      chk("R10", "ctl untouched", d, {24'h0, ctl[n]});
    end
    wr(a_clr(0, 0), 32'hFFFF_FFFF);
    mb[0] = '0;

    // R7, R8, R9: every request pattern against every routing word, per core
    for (int n = 0; n < NC; n++) begin
      for (int p = 0; p < 16; p++) begin
        for (int m = 0; m < NB; m++) begin
          if (p[m]) begin
            wr(a_set(n, m), 32'h1 << (m*7 + n));
            mb[n*NB+m] = mb[n*NB+m] | (32'h1 << (m*7 + n));
          end else begin
            wr(a_clr(n, m), 32'hFFFF_FFFF);
            mb[n*NB+m] = '0;
          end
        end
        for (int c = 0; c < 256; c++) begin
          wr(8'(8'h50 + 4*n), 32'(c));
          ctl[n] = 8'(c);
          chk_lines("R8");
          chk_pend(n, "R9");
        end
      end
      wr(8'(8'h50 + 4*n), 32'h0);
      ctl[n] = '0;
      for (int m = 0; m < NB; m++) begin
        wr(a_clr(n, m), 32'hFFFF_FFFF);
        mb[n*NB+m] = '0;
      end
    end
    chk_lines("R7");
    chk_boxes("R3");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule